// File: doc/BRIEF.md
# Serial Bus Link Transmit Sequencer

This block turns outbound traffic into framed serial-bus packets and feeds them, one 32-bit quadlet at a time, to the PHY side of a link layer. Two sources compete for the transmitter. The first is an asynchronous transmit queue, read like a show-ahead FIFO. The second is a streaming isochronous port with a valid/ready handshake. Each quadlet from either source carries two flags. One marks the last header quadlet and the other marks the last quadlet of the packet.

An asynchronous packet waiting in the queue raises a bus request at once. Isochronous data does not. It is held back until a cycle tick has opened a new isochronous cycle, and each tick allows one isochronous packet. When the node is configured as cycle master, every tick also makes the block build a cycle-start packet by itself, and that packet goes ahead of everything else. The block appends a CRC-32 after the header and, when the packet has a payload, a second CRC-32 after the payload. It drives the bus request to the PHY and streams quadlets only after a grant.

Top module: `lk_tx_sequencer`

## Requirements
- R1: After reset `phy_req`, `phy_tx_valid`, `aq_rd_en` and `iso_ready` are all low.
- R2: A non-empty asynchronous queue raises `phy_req` without waiting for a tick. Quadlets are never taken from both sources in the same cycle.
- R3: Isochronous data alone never raises `phy_req`. After a `cycle_tick`, exactly one isochronous packet is sent, and a further packet waits for the next tick.
- R4: With `cfg_cycle_master` high, each `cycle_tick` produces a cycle-start packet. Header quadlet 0 is 0xFFFF0080: destination 0xFFFF in bits 31:16 and transaction code 0x8 in bits 7:4. Header quadlet 1 is the `cycle_time` value sampled at the tick. A header CRC follows, and there is no payload. With `cfg_cycle_master` low, a tick sends no cycle-start packet.
- R5: A cycle-start packet goes ahead of any other source. This holds both when its tick coincides with a new selection and when it arrives while another request still waits for grant without grant present. A tick-armed isochronous packet goes ahead of queued asynchronous data.
- R6: Each CRC-32 uses polynomial 0x04C11DB7, starts from 0xFFFFFFFF and runs MSB first with no reflection and no final inversion. The header CRC covers the header quadlets and follows the quadlet flagged header-end. The data CRC covers only the payload quadlets and follows the quadlet flagged last.
- R7: One quadlet moves per cycle with `phy_tx_valid` and `phy_tx_ready` both high. While it is not accepted, data and `phy_tx_last` hold. `phy_tx_last` is set only on the final CRC quadlet.
- R8: Until `phy_grant` is seen, `phy_req` stays high and no source quadlet is popped. `phy_req` is low in the cycle after the final quadlet is accepted.
- R9: A quadlet flagged both header-end and last ends the packet with the header CRC alone, so a two-quadlet header gives three quadlets on the wire.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_cycle_master | input | 1 | Node acts as cycle master |
| cycle_tick | input | 1 | One-cycle pulse opening an isochronous cycle |
| cycle_time | input | 32 | Current cycle-time value |
| aq_empty | input | 1 | Asynchronous queue has no quadlet |
| aq_rd_data | input | 32 | Head quadlet of the asynchronous queue |
| aq_rd_hdr_end | input | 1 | Head quadlet is the last header quadlet |
| aq_rd_last | input | 1 | Head quadlet is the last of its packet |
| aq_rd_en | output | 1 | Pop the asynchronous queue head |
| iso_valid | input | 1 | Isochronous quadlet offered |
| iso_data | input | 32 | Isochronous quadlet |
| iso_hdr_end | input | 1 | Offered quadlet is the last header quadlet |
| iso_last | input | 1 | Offered quadlet is the last of its packet |
| iso_ready | output | 1 | Isochronous quadlet taken this cycle |
| phy_req | output | 1 | Bus arbitration request |
| phy_grant | input | 1 | Arbitration won |
| phy_tx_valid | output | 1 | Transmit quadlet valid |
| phy_tx_data | output | 32 | Transmit quadlet |
| phy_tx_last | output | 1 | Final quadlet of the packet |
| phy_tx_ready | input | 1 | PHY accepts the quadlet |

## Verification
A cycle tick can land in the same cycle as a source selection, or while an asynchronous request is still waiting for grant. Both collisions are provoked. In the first, a tick is pulsed together with freshly pushed asynchronous and isochronous packets. In the second, grant is withheld until a tick has arrived during the wait. In each case the quadlet stream seen by the PHY is compared on every clock against a queue of expected quadlets, built in the order cycle-start, isochronous, asynchronous. Any reordering, lost packet or extra packet shows up as a mismatch, and a quadlet popped before grant is flagged in the cycle it happens.

// File: rtl/lk_tx_pkg.sv
package lk_tx_pkg;
  typedef enum logic [1:0] {SRC_ASY = 2'd0, SRC_ISO = 2'd1, SRC_CYC = 2'd2} src_e;
  typedef enum logic [2:0] {PH_HDR, PH_HCRC, PH_DATA, PH_DCRC, PH_END} phase_e;
  typedef enum logic [1:0] {AR_IDLE, AR_WAIT, AR_BUSY} arb_e;
endpackage

// File: rtl/lk_tx_crc32.sv
module lk_tx_crc32 #(
  parameter int          QW   = 32,
  parameter logic [31:0] POLY = 32'h04C11DB7
) (
  input  logic [31:0]   crc_in,
  input  logic [QW-1:0] word,
  output logic [31:0]   crc_out
);
  always_comb begin
    logic [31:0] c;
    c = crc_in;
    for (int b = QW - 1; b >= 0; b--) begin
      if (c[31] ^ word[b]) c = {c[30:0], 1'b0} ^ POLY;
      else                 c = {c[30:0], 1'b0};
    end
    crc_out = c;
  end
endmodule

// File: rtl/lk_tx_arbiter.sv
module lk_tx_arbiter
  import lk_tx_pkg::*;
#(
  parameter int QW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cfg_cycle_master,
  input  logic          cycle_tick,
  input  logic [QW-1:0] cycle_time,
  input  logic          aq_has,
  input  logic          iso_has,
  input  logic          phy_grant,
  input  logic          pkt_done,
  output logic          phy_req,
  output logic          busy,
  output logic          waiting,
  output src_e          src,
  output logic [QW-1:0] cs_time
);
  arb_e st;
  logic cs_pending, iso_armed, cs_want;

  assign cs_want = cs_pending | (cycle_tick & cfg_cycle_master);
  assign busy    = (st == AR_BUSY);
  assign waiting = (st == AR_WAIT);

  always_ff @(posedge clk) begin
    if (rst) begin
      st         <= AR_IDLE;
      phy_req    <= 1'b0;
      cs_pending <= 1'b0;
      iso_armed  <= 1'b0;
      src        <= SRC_ASY;
      cs_time    <= '0;
    end else begin
      if (cycle_tick && cfg_cycle_master) begin
        cs_pending <= 1'b1;
        cs_time    <= cycle_time;
      end
      case (st)
        AR_IDLE: begin
          if (cs_want) begin
            src <= SRC_CYC; cs_pending <= 1'b0; st <= AR_WAIT; phy_req <= 1'b1;
          end else if (iso_armed && iso_has) begin
            src <= SRC_ISO; st <= AR_WAIT; phy_req <= 1'b1;
          end else if (aq_has) begin
            src <= SRC_ASY; st <= AR_WAIT; phy_req <= 1'b1;
          end
        end
        AR_WAIT: begin
          if (phy_grant) begin
            st <= AR_BUSY;
            if (src == SRC_ISO) iso_armed <= 1'b0;
          end else if (cs_want && src != SRC_CYC) begin
            src        <= SRC_CYC;
            cs_pending <= 1'b0;
          end
        end
        AR_BUSY: begin
          if (pkt_done) begin
            st      <= AR_IDLE;
            phy_req <= 1'b0;
          end
        end
        default: st <= AR_IDLE;
      endcase
      if (cycle_tick) iso_armed <= 1'b1;
    end
  end
endmodule

// File: rtl/lk_tx_framer.sv
module lk_tx_framer
  import lk_tx_pkg::*;
#(
  parameter int          QW       = 32,
  parameter logic [31:0] POLY     = 32'h04C11DB7,
  parameter logic [15:0] CS_DEST  = 16'hFFFF,
  parameter logic [3:0]  CS_TCODE = 4'h8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          active,
  input  src_e          src,
  input  logic [QW-1:0] cs_time,
  input  logic [QW-1:0] aq_data,
  input  logic          aq_hdr_end,
  input  logic          aq_last,
  input  logic          aq_avail,
  input  logic [QW-1:0] iso_data,
  input  logic          iso_hdr_end,
  input  logic          iso_last,
  input  logic          iso_avail,
  input  logic          tx_ready,
  output logic          aq_pop,
  output logic          iso_take,
  output logic          tx_valid,
  output logic [QW-1:0] tx_data,
  output logic          tx_last,
  output logic          pkt_done
);
  localparam logic [31:0] CRC_INIT = 32'hFFFFFFFF;
  localparam logic [QW-1:0] CS_Q0 = {CS_DEST, {(QW-24){1'b0}}, CS_TCODE, 4'h0};

  phase_e        phase;
  logic [31:0]   crc_q, crc_nx;
  logic          cs_idx, has_data;
  logic [QW-1:0] w_data;
  logic          w_hend, w_last, w_av;
  logic          can_load, take, crc_load, payload_ph;

  always_comb begin
    case (src)
      SRC_ASY: begin w_data = aq_data;  w_hend = aq_hdr_end;  w_last = aq_last;  w_av = aq_avail;  end
      SRC_ISO: begin w_data = iso_data; w_hend = iso_hdr_end; w_last = iso_last; w_av = iso_avail; end
      default: begin
        w_data = cs_idx ? cs_time : CS_Q0;
        w_hend = cs_idx;
        w_last = cs_idx;
        w_av   = 1'b1;
      end
    endcase
  end

  lk_tx_crc32 #(.QW(QW), .POLY(POLY)) u_crc (.crc_in(crc_q), .word(w_data), .crc_out(crc_nx));

  assign can_load   = !tx_valid || tx_ready;
  assign payload_ph = (phase == PH_HDR) || (phase == PH_DATA);
  assign take       = active && can_load && payload_ph && w_av;
  assign crc_load   = active && can_load && ((phase == PH_HCRC) || (phase == PH_DCRC));
  assign aq_pop     = take && (src == SRC_ASY);
  assign iso_take   = take && (src == SRC_ISO);
  assign pkt_done   = tx_valid && tx_ready && tx_last;

  always_ff @(posedge clk) begin
    if (rst) begin
      phase    <= PH_HDR;
      crc_q    <= CRC_INIT;
      cs_idx   <= 1'b0;
      has_data <= 1'b0;
      tx_valid <= 1'b0;
      tx_data  <= '0;
      tx_last  <= 1'b0;
    end else begin
      if (can_load) tx_valid <= take || crc_load;
      if (take) begin
        tx_data <= w_data;
        tx_last <= 1'b0;
        crc_q   <= crc_nx;
        if (phase == PH_HDR) begin
          cs_idx <= 1'b1;
          if (w_hend) begin
            phase    <= PH_HCRC;
            has_data <= !w_last;
          end
        end else if (w_last) begin
          phase <= PH_DCRC;
        end
      end
      if (crc_load) begin
        tx_data <= crc_q[QW-1:0];
        tx_last <= (phase == PH_DCRC) || !has_data;
        crc_q   <= CRC_INIT;
        phase   <= (phase == PH_HCRC && has_data) ? PH_DATA : PH_END;
      end
      if (pkt_done) begin
        phase  <= PH_HDR;
        cs_idx <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/lk_tx_sequencer.sv
module lk_tx_sequencer
  import lk_tx_pkg::*;
#(
  parameter int          QW       = 32,
  parameter logic [31:0] POLY     = 32'h04C11DB7,
  parameter logic [15:0] CS_DEST  = 16'hFFFF,
  parameter logic [3:0]  CS_TCODE = 4'h8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cfg_cycle_master,
  input  logic          cycle_tick,
  input  logic [QW-1:0] cycle_time,
  input  logic          aq_empty,
  input  logic [QW-1:0] aq_rd_data,
  input  logic          aq_rd_hdr_end,
  input  logic          aq_rd_last,
  output logic          aq_rd_en,
  input  logic          iso_valid,
  input  logic [QW-1:0] iso_data,
  input  logic          iso_hdr_end,
  input  logic          iso_last,
  output logic          iso_ready,
  output logic          phy_req,
  input  logic          phy_grant,
  output logic          phy_tx_valid,
  output logic [QW-1:0] phy_tx_data,
  output logic          phy_tx_last,
  input  logic          phy_tx_ready
);
  logic          busy, arb_wait, pkt_done;
  src_e          src;
  logic [QW-1:0] cs_time;

  lk_tx_arbiter #(.QW(QW)) u_arb (
    .clk(clk), .rst(rst), .cfg_cycle_master(cfg_cycle_master),
    .cycle_tick(cycle_tick), .cycle_time(cycle_time),
    .aq_has(!aq_empty), .iso_has(iso_valid), .phy_grant(phy_grant),
    .pkt_done(pkt_done), .phy_req(phy_req), .busy(busy), .waiting(arb_wait),
    .src(src), .cs_time(cs_time)
  );

  lk_tx_framer #(.QW(QW), .POLY(POLY), .CS_DEST(CS_DEST), .CS_TCODE(CS_TCODE)) u_frm (
    .clk(clk), .rst(rst), .active(busy), .src(src), .cs_time(cs_time),
    .aq_data(aq_rd_data), .aq_hdr_end(aq_rd_hdr_end), .aq_last(aq_rd_last),
    .aq_avail(!aq_empty), .iso_data(iso_data), .iso_hdr_end(iso_hdr_end),
    .iso_last(iso_last), .iso_avail(iso_valid), .tx_ready(phy_tx_ready),
    .aq_pop(aq_rd_en), .iso_take(iso_ready), .tx_valid(phy_tx_valid),
    .tx_data(phy_tx_data), .tx_last(phy_tx_last), .pkt_done(pkt_done)
  );
endmodule

// File: rtl/lk_tx_sequencer_chk.sv
module lk_tx_sequencer_chk #(
  parameter int QW = 32
) (
  input logic          clk,
  input logic          rst,
  input logic          arb_wait,
  input logic          aq_rd_en,
  input logic          iso_ready,
  input logic          iso_valid,
  input logic          phy_req,
  input logic          phy_grant,
  input logic          phy_tx_valid,
  input logic [QW-1:0] phy_tx_data,
  input logic          phy_tx_last,
  input logic          phy_tx_ready
);
  a_r8_no_move_before_grant: assert property (@(posedge clk) disable iff (rst)
    arb_wait |-> (!aq_rd_en && !iso_ready && !phy_tx_valid));

  a_r8_req_held: assert property (@(posedge clk) disable iff (rst)
    (arb_wait && !phy_grant) |=> phy_req);

  a_r8_req_drop: assert property (@(posedge clk) disable iff (rst)
    (phy_tx_valid && phy_tx_ready && phy_tx_last) |=> !phy_req);

  a_r8_valid_needs_req: assert property (@(posedge clk) disable iff (rst)
    phy_tx_valid |-> phy_req);

  a_r7_hold_stable: assert property (@(posedge clk) disable iff (rst)
    (phy_tx_valid && !phy_tx_ready) |=>
      (phy_tx_valid && $stable(phy_tx_data) && $stable(phy_tx_last)));

  a_r2_one_source: assert property (@(posedge clk) disable iff (rst)
    !(aq_rd_en && iso_ready));

  a_r3_take_only_offered: assert property (@(posedge clk) disable iff (rst)
    iso_ready |-> iso_valid);
endmodule

bind lk_tx_sequencer lk_tx_sequencer_chk #(.QW(QW)) u_chk (
  .clk(clk), .rst(rst), .arb_wait(arb_wait), .aq_rd_en(aq_rd_en),
  .iso_ready(iso_ready), .iso_valid(iso_valid), .phy_req(phy_req),
  .phy_grant(phy_grant), .phy_tx_valid(phy_tx_valid), .phy_tx_data(phy_tx_data),
  .phy_tx_last(phy_tx_last), .phy_tx_ready(phy_tx_ready)
);

// File: tb/test_lk_tx_sequencer.sv
`timescale 1ns/1ps
module test_lk_tx_sequencer;
  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst = 1'b1, cfg_cycle_master = 1'b0, cycle_tick = 1'b0;
  logic [31:0] cycle_time = '0;
  logic aq_empty = 1'b1, aq_rd_hdr_end = 1'b0, aq_rd_last = 1'b0;
  logic [31:0] aq_rd_data = '0;
  logic iso_valid = 1'b0, iso_hdr_end = 1'b0, iso_last = 1'b0;
  logic [31:0] iso_data = '0;
  logic phy_grant = 1'b0, phy_tx_ready = 1'b1;
  logic aq_rd_en, iso_ready, phy_req, phy_tx_valid, phy_tx_last;
  logic [31:0] phy_tx_data;

  lk_tx_sequencer i_lk_tx_sequencer (
    .clk(clk), .rst(rst), .cfg_cycle_master(cfg_cycle_master), .cycle_tick(cycle_tick),
    .cycle_time(cycle_time), .aq_empty(aq_empty), .aq_rd_data(aq_rd_data),
    .aq_rd_hdr_end(aq_rd_hdr_end), .aq_rd_last(aq_rd_last), .aq_rd_en(aq_rd_en),
    .iso_valid(iso_valid), .iso_data(iso_data), .iso_hdr_end(iso_hdr_end),
    .iso_last(iso_last), .iso_ready(iso_ready), .phy_req(phy_req), .phy_grant(phy_grant),
    .phy_tx_valid(phy_tx_valid), .phy_tx_data(phy_tx_data), .phy_tx_last(phy_tx_last),
    .phy_tx_ready(phy_tx_ready)
  );

  int checks = 0, fails = 0, cyc = 0, tx_count = 0;
  bit finished = 0;
  logic [33:0] aq_q[$], iso_q[$], exp_q[$];   // src: {hdr_end,last,data}; exp: {is_crc,last,data}
  logic [31:0] pb[0:15];
  int nh, nd;
  bit rec_aq_pop, rec_iso_pop, gnt_given, gnt_hold, last_acc, hold_pend, hold_last;
  logic [31:0] hold_data;
  int gnt_delay = 2, gcnt = 0, ready_mode = 0;
  bit tick_req = 0;
  logic [31:0] tick_time = '0;

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s at cycle %0d: actual=%h expected=%h", req, cyc, act, expv);
    end
  endtask

  function automatic logic [31:0] crc_ref(input int from, input int n);
    logic [31:0] c = 32'hFFFFFFFF;
    for (int k = from; k < from + n; k++)
      for (int b = 31; b >= 0; b--) begin
        bit fb = c[31] ^ pb[k][b];
        c = c << 1;
        if (fb) c = c ^ 32'h04C11DB7;
      end
    return c;
  endfunction

  task automatic build(input int seed, input int h, input int d);
    nh = h; nd = d;
    for (int k = 0; k < h + d; k++) pb[k] = 32'h9E3779B9 * (seed * 16 + k + 1) ^ (seed << 20);
  endtask

  task automatic exp_pkt();
    for (int k = 0; k < nh; k++) exp_q.push_back({2'b00, pb[k]});
    exp_q.push_back({1'b1, (nd == 0), crc_ref(0, nh)});
    if (nd > 0) begin
      for (int k = 0; k < nd; k++) exp_q.push_back({2'b00, pb[nh + k]});
      exp_q.push_back({2'b11, crc_ref(nh, nd)});
    end
  endtask

  task automatic src_pkt(input bit to_iso);
    for (int k = 0; k < nh + nd; k++) begin
      logic [33:0] e;
      e = {(k == nh - 1), (k == nh + nd - 1), pb[k]};
      if (to_iso) iso_q.push_back(e); else aq_q.push_back(e);
    end
  endtask

  task automatic exp_cs(input logic [31:0] t);
    nh = 2; nd = 0; pb[0] = 32'hFFFF0080; pb[1] = t;
    exp_pkt();
  endtask

  task automatic step();
    @(negedge clk);
    cyc++;
    if (rec_aq_pop && aq_q.size() > 0) void'(aq_q.pop_front());
    if (rec_iso_pop && iso_q.size() > 0) void'(iso_q.pop_front());
    aq_empty = (aq_q.size() == 0);
    if (!aq_empty) {aq_rd_hdr_end, aq_rd_last, aq_rd_data} = aq_q[0];
    iso_valid = (iso_q.size() != 0);
    if (iso_valid) {iso_hdr_end, iso_last, iso_data} = iso_q[0];
    phy_tx_ready = (ready_mode == 0) ? 1'b1 : ((cyc % 3) != 1);
    cycle_tick = tick_req; cycle_time = tick_time; tick_req = 0;
    phy_grant = 1'b0;
    if (phy_req && !gnt_given && !gnt_hold) begin
      if (gcnt >= gnt_delay) begin phy_grant = 1'b1; gnt_given = 1; gcnt = 0; end
      else gcnt++;
    end
    #1;
    if (rst) begin rec_aq_pop = 0; rec_iso_pop = 0; return; end
    if (phy_req && !gnt_given)
      chk(!aq_rd_en && !iso_ready && !phy_tx_valid, "R8 moved before grant",
          {aq_rd_en, iso_ready, phy_tx_valid}, 0);
    if (last_acc) begin chk(!phy_req, "R8 req after last", phy_req, 0); last_acc = 0; end
    if (hold_pend) begin
      chk(phy_tx_valid && phy_tx_data == hold_data && phy_tx_last == hold_last, "R7 hold",
          {phy_tx_valid, phy_tx_last, phy_tx_data}, {1'b1, hold_last, hold_data});
      hold_pend = 0;
    end
    if (phy_tx_valid && !phy_tx_ready) begin
      hold_pend = 1; hold_data = phy_tx_data; hold_last = phy_tx_last;
    end
    if (phy_tx_valid && phy_tx_ready) begin
      tx_count++;
      if (exp_q.size() == 0) chk(0, "R5 R7 unexpected quadlet", {phy_tx_last, phy_tx_data}, 0);
      else begin
        logic [33:0] e;
        e = exp_q.pop_front();
        chk({phy_tx_last, phy_tx_data} == e[32:0], e[33] ? "R6 crc quadlet" : "R7 quadlet",
            {phy_tx_last, phy_tx_data}, e[32:0]);
      end
      if (phy_tx_last) begin gnt_given = 0; last_acc = 1; end
    end
    if (aq_rd_en && iso_ready) chk(0, "R2 both sources", 2'b11, 0);
    rec_aq_pop = aq_rd_en; rec_iso_pop = iso_ready;
  endtask

  task automatic drain(input string tag);
    int n = 0;
    while ((exp_q.size() != 0 || phy_req || phy_tx_valid) && n < 400) begin step(); n++; end
    chk(exp_q.size() == 0, tag, exp_q.size(), 0);
    step();
  endtask

  initial begin
    #(8 * 150000);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", checks + 1, fails);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 4; i++) step();
    rst = 1'b0;
    step();
    // R1 reset state
    chk(!phy_req && !phy_tx_valid && !aq_rd_en && !iso_ready, "R1 reset outputs",
        {phy_req, phy_tx_valid, aq_rd_en, iso_ready}, 0);

    // R2, R9: header-only asynchronous packet, delayed grant
    build(1, 2, 0); src_pkt(0); exp_pkt();
    gnt_delay = 5; tx_count = 0;
    step(); step();
    chk(phy_req, "R2 async request", phy_req, 1);
    chk(aq_q.size() == 2, "R8 queue untouched before grant", aq_q.size(), 2);
    drain("R2 async packet");
    chk(tx_count == 3, "R9 header-only length", tx_count, 3);

    // R6, R7: block packet with a stalling PHY
    gnt_delay = 0; ready_mode = 1;
    build(2, 4, 5); src_pkt(0); exp_pkt();
    drain("R6 block packet");
    ready_mode = 0;

    // R3: isochronous waits for tick, one packet per tick
    build(3, 1, 3); src_pkt(1);
    for (int i = 0; i < 15; i++) step();
    chk(!phy_req && iso_q.size() == 4, "R3 iso held", {phy_req, iso_q.size()}, 4);
    exp_pkt(); tick_req = 1; tick_time = 32'h11;
    drain("R3 iso after tick");
    build(4, 2, 2); src_pkt(1);
    for (int i = 0; i < 10; i++) step();
    chk(!phy_req, "R3 second iso waits", phy_req, 0);
    exp_pkt(); tick_req = 1;
    drain("R3 second iso");

    // R4: cycle master sends cycle-start
    cfg_cycle_master = 1'b1;
    exp_cs(32'h12345678); tick_req = 1; tick_time = 32'h12345678;
    drain("R4 cycle-start");

    // R5: tick while async waits for grant
    build(5, 2, 2); src_pkt(0);
    gnt_hold = 1;
    for (int i = 0; i < 4; i++) step();
    chk(phy_req, "R8 req held without grant", phy_req, 1);
    exp_cs(32'hCAFE0001); tick_req = 1; tick_time = 32'hCAFE0001;
    build(5, 2, 2); exp_pkt();
    step(); step();
    gnt_hold = 0;
    drain("R5 preempt waiting request");

    // R5: tick coincident with new iso and async data
    build(6, 2, 0); src_pkt(0);
    build(7, 1, 2); src_pkt(1);
    tick_req = 1; tick_time = 32'h0BADF00D;
    exp_cs(32'h0BADF00D);
    build(7, 1, 2); exp_pkt();
    build(6, 2, 0); exp_pkt();
    drain("R5 order cs iso async");

    // R4: no cycle-start when not master
    cfg_cycle_master = 1'b0;
    tick_req = 1;
    for (int i = 0; i < 10; i++) step();
    chk(!phy_req && !phy_tx_valid, "R4 no cycle-start", {phy_req, phy_tx_valid}, 0);

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end
endmodule